// File: doc/BRIEF.md
# Byte-Masked Unaligned Store Unit

This unit takes one store request at a time and turns it into writes on a 128-bit memory write port. The port is aligned to 16 bytes and carries 16 byte-enable lines. Each request carries a 128-bit data word, a 128-bit mask word, a base address and an address-size mode. Only bit 7 of each mask byte counts: it decides whether the matching data byte is stored. The base address can sit at any byte offset, so one request may touch two aligned 16-byte blocks. In that case the unit issues a lower beat followed by an upper beat.

The unit never reads memory. Bytes that are not written keep their old contents only because their byte enables stay low. A beat with no enabled byte is never put on the bus, so a mask with no top bit set produces no write at all. The address is first cut to 16, 32 or 64 bits according to the mode. The upper beat's address wraps inside that same width.

Both the request side and the memory side use a valid/ready handshake. The unit stays busy from the cycle it accepts a request until the memory port takes the last beat.

Top module: `mstore_unit`

## Requirements
- R1: Data lane i is written only when bit 7 of mask byte i (mask bit 8*i+7) is 1. Bits 0..6 of every mask byte have no effect on any write.
- R2: With byte offset k = truncated address bits [3:0], source byte i lands in lane (k+i) of the lower beat when k+i < 16, and otherwise in lane (k+i-16) of the upper beat. On the memory port, lane j is memData[8*j+7:8*j] and memBe[j].
- R3: The lower beat's address is the truncated address with bits [3:0] cleared. Truncation depends on reqMode: 0 keeps the low 16 bits, 1 keeps the low 32 bits, 2 and 3 keep all 64 bits.
- R4: The upper beat's address is the lower beat's address plus 16, wrapped to the width selected by reqMode.
- R5: When the byte offset is zero, at most one beat (the lower one) is issued.
- R6: A beat whose byte enables are all zero is never issued, so a request with no mask top bit set causes no memory write.
- R7: When both beats are issued, the lower-address beat is accepted before the upper one, and no other beat follows between the upper beat and the next request.
- R8: reqReady is high while idle. It drops in the cycle after a request that needs at least one beat is accepted, and returns only after the last beat is accepted by the memory port.
- R9: While memValid is high and memReady is low, memValid, memAddr, memData and memBe hold their values.
- R10: After reset, reqReady is 1 and memValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Store request present |
| reqReady | output | 1 | Unit can accept a request |
| reqData | input | 128 | Source bytes, byte i at bits 8i+7..8i |
| reqMask | input | 128 | Mask bytes; bit 7 of each enables the matching lane |
| reqAddr | input | 64 | Byte address of source byte 0 |
| reqMode | input | 2 | Address width: 0 = 16-bit, 1 = 32-bit, 2/3 = 64-bit |
| memValid | output | 1 | Write beat present |
| memReady | input | 1 | Memory port takes the beat |
| memAddr | output | 64 | Aligned beat address |
| memData | output | 128 | Beat data, lane j at bits 8j+7..8j |
| memBe | output | 16 | Byte enables per lane |

## Verification
The assertions assume that reset is applied before any request arrives and that memReady is only meaningful while memValid is high. They make no assumption about the request inputs while the unit is busy, because the unit captures a request only when it accepts it. The stimulus holds each request steady until it is accepted and drops reqValid right after. It toggles memReady pseudo-randomly so that stalls fall on both lower and upper beats. Offsets, modes and masks include the wrap points of the 16-bit and 32-bit address spaces.

// File: rtl/mstore_pkg.sv
package mstore_pkg;
  typedef enum logic [1:0] {
    MODE_A16 = 2'd0,
    MODE_A32 = 2'd1,
    MODE_A64 = 2'd2
  } amode_e;

  typedef struct packed {
    logic load;   // capture request and build beats
    logic selHi;  // present the upper beat on the port
  } strobe_t;
endpackage

// File: rtl/mstore_dp.sv
module mstore_dp
  import mstore_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned ADDR_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [LANES*8-1:0]    inData,
  input  logic [LANES*8-1:0]    inMask,
  input  logic [ADDR_W-1:0]     inAddr,
  input  logic [1:0]            inMode,
  output logic                  loAny,
  output logic                  hiAny,
  output logic [ADDR_W-1:0]     outAddr,
  output logic [LANES*8-1:0]    outData,
  output logic [LANES-1:0]      outBe
);
  localparam int unsigned DW    = LANES * 8;
  localparam int unsigned OFF_W = $clog2(LANES);

  logic [LANES-1:0]   laneEn;
  logic [ADDR_W-1:0]  widthMask;
  logic [ADDR_W-1:0]  truncAddr;
  logic [OFF_W-1:0]   offset;
  logic [ADDR_W-1:0]  baseLo;
  logic [ADDR_W-1:0]  baseHi;
  logic [2*LANES-1:0] wideBe;
  logic [2*DW-1:0]    wideData;

  // only the top bit of each mask byte is an enable
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneEn[i] = inMask[8*i+7];
  end

  always_comb begin
    for (int b = 0; b < ADDR_W; b++) begin
      unique case (amode_e'(inMode))
        MODE_A16: widthMask[b] = (b < 16);
        MODE_A32: widthMask[b] = (b < 32);
        default:  widthMask[b] = 1'b1;
      endcase
    end
  end

  assign truncAddr = inAddr & widthMask;
  assign offset    = truncAddr[OFF_W-1:0];
  assign baseLo    = {truncAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign baseHi    = (baseLo + ADDR_W'(LANES)) & widthMask;
  assign wideBe    = {{LANES{1'b0}}, laneEn} << offset;
  assign wideData  = {{DW{1'b0}}, inData} << {offset, 3'b000};
  assign loAny     = |wideBe[LANES-1:0];
  assign hiAny     = |wideBe[2*LANES-1:LANES];

  logic [ADDR_W-1:0] loAddrQ, hiAddrQ;
  logic [DW-1:0]     loDataQ, hiDataQ;
  logic [LANES-1:0]  loBeQ,   hiBeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loAddrQ <= '0;
      hiAddrQ <= '0;
      loDataQ <= '0;
      hiDataQ <= '0;
      loBeQ   <= '0;
      hiBeQ   <= '0;
    end else if (strb.load) begin
      loAddrQ <= baseLo;
      hiAddrQ <= baseHi;
      loDataQ <= wideData[DW-1:0];
      hiDataQ <= wideData[2*DW-1:DW];
      loBeQ   <= wideBe[LANES-1:0];
      hiBeQ   <= wideBe[2*LANES-1:LANES];
    end
  end

  assign outAddr = strb.selHi ? hiAddrQ : loAddrQ;
  assign outData = strb.selHi ? hiDataQ : loDataQ;
  assign outBe   = strb.selHi ? hiBeQ   : loBeQ;

  // R5: a zero offset never yields an upper beat
  a_r5_no_hi_at_zero_offset: assert property (@(posedge clk) disable iff (!rstN)
    (offset == '0) |-> !hiAny);
endmodule

// File: rtl/mstore_ctl.sv
module mstore_ctl
  import mstore_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  logic    memReady,
  output logic    memValid,
  input  logic    loAny,
  input  logic    hiAny,
  output strobe_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} state_e;

  state_e stateQ, stateD;
  logic   hiPendQ;
  logic   accept;

  assign reqReady = (stateQ == ST_IDLE);
  assign memValid = (stateQ != ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (accept) stateD = loAny ? ST_LO : (hiAny ? ST_HI : ST_IDLE);
      ST_LO:   if (memReady) stateD = hiPendQ ? ST_HI : ST_IDLE;
      ST_HI:   if (memReady) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      hiPendQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) hiPendQ <= hiAny;
    end
  end

  assign strb.load  = accept;
  assign strb.selHi = (stateQ == ST_HI);

  // R8: a request that needs a beat makes the unit busy
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (loAny || hiAny)) |=> !reqReady);
  // R6: an empty request leaves the unit idle
  a_r6_empty_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !loAny && !hiAny) |=> (reqReady && !memValid));
  // R7: nothing follows the upper beat
  a_r7_hi_is_last: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && strb.selHi && memReady) |=> !memValid);
  // R9: a stalled beat stays put
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(strb.selHi)));
endmodule

// File: rtl/mstore_unit.sv
module mstore_unit
  import mstore_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned ADDR_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [LANES*8-1:0]   reqData,
  input  logic [LANES*8-1:0]   reqMask,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqMode,
  output logic                 memValid,
  input  logic                 memReady,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [LANES*8-1:0]   memData,
  output logic [LANES-1:0]     memBe
);
  localparam int unsigned OFF_W = $clog2(LANES);

  strobe_t strb;
  logic    loAny, hiAny;

  mstore_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .memReady(memReady), .memValid(memValid), .loAny(loAny), .hiAny(hiAny),
    .strb(strb)
  );

  mstore_dp #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(reqData), .inMask(reqMask),
    .inAddr(reqAddr), .inMode(reqMode), .loAny(loAny), .hiAny(hiAny),
    .outAddr(memAddr), .outData(memData), .outBe(memBe)
  );

  // R6: no beat on the bus without an enabled byte
  a_r6_no_empty_beat: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (|memBe));
  // R3: beats are aligned
  a_r3_aligned_beat: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddr[OFF_W-1:0] == '0));
  // R9: payload held during a stall
  a_r9_payload_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> ($stable(memAddr) && $stable(memData) && $stable(memBe)));
endmodule

// File: tb/mstore_unit_test.sv
module mstore_unit_test;
  typedef struct {
    logic [63:0]  addr;
    logic [127:0] data;
    logic [15:0]  be;
  } beat_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [127:0] reqData = '0;
  logic [127:0] reqMask = '0;
  logic [63:0]  reqAddr = '0;
  logic [1:0]   reqMode = '0;
  logic         memValid;
  logic         memReady = 1'b0;
  logic [63:0]  memAddr;
  logic [127:0] memData;
  logic [15:0]  memBe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int readyPct = 70;
  bit done = 1'b0;
  beat_t expQ[$];

  always #4 clk = ~clk;

  mstore_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqData(reqData), .reqMask(reqMask), .reqAddr(reqAddr), .reqMode(reqMode),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .memBe(memBe)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual cycles %0d, expected completion", cycles);
      finishRun();
    end
  end

  always @(negedge clk) memReady <= ($urandom_range(99) < readyPct);

  // expected beats built lane by lane from R1..R4
  task automatic expect_req(input logic [127:0] d, input logic [127:0] m,
                            input logic [63:0] a, input logic [1:0] mode, output bit busy);
    logic [63:0] wm, t, lo, hi;
    beat_t bl, bh;
    int off;
    wm = (mode == 2'd0) ? 64'hFFFF : (mode == 2'd1) ? 64'hFFFF_FFFF : '1;
    t  = a & wm;
    off = int'(t[3:0]);
    lo = {t[63:4], 4'h0};
    hi = (lo + 64'd16) & wm;
    bl.addr = lo; bl.data = '0; bl.be = '0;
    bh.addr = hi; bh.data = '0; bh.be = '0;
    for (int i = 0; i < 16; i++) begin
      if (m[8*i+7]) begin
        if (off + i < 16) begin
          bl.be[off+i] = 1'b1; bl.data[8*(off+i) +: 8] = d[8*i +: 8];
        end else begin
          bh.be[off+i-16] = 1'b1; bh.data[8*(off+i-16) +: 8] = d[8*i +: 8];
        end
      end
    end
    if (|bl.be) expQ.push_back(bl);
    if (|bh.be) expQ.push_back(bh);
    busy = (|bl.be) || (|bh.be);
  endtask

  task automatic send(input logic [127:0] d, input logic [127:0] m,
                      input logic [63:0] a, input logic [1:0] mode);
    bit busy;
    @(negedge clk); #1;
    while (!reqReady) begin @(negedge clk); #1; end
    expect_req(d, m, a, mode, busy);
    reqData = d; reqMask = m; reqAddr = a; reqMode = mode; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk); #1;
    reqValid = 1'b0;
    checks++;
    if (reqReady !== !busy) begin
      errors++;
      $display("FAIL R8/R6 ready after accept: actual %0b expected %0b", reqReady, !busy);
    end
  endtask

  task automatic drain();
    @(negedge clk); #1;
    while (expQ.size() != 0 || !reqReady) begin @(negedge clk); #1; end
  endtask

  // monitor: compares accepted beats, checks stall stability
  beat_t stallBeat;
  bit    stalled = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (stalled) begin
        checks++;
        if (!memValid || memAddr !== stallBeat.addr || memBe !== stallBeat.be ||
            memData !== stallBeat.data) begin
          errors++;
          $display("FAIL R9 stall hold: actual v%0b %h %h expected %h %h",
                   memValid, memAddr, memBe, stallBeat.addr, stallBeat.be);
        end
      end
      stalled = memValid && !memReady;
      stallBeat.addr = memAddr; stallBeat.data = memData; stallBeat.be = memBe;
      if (memValid && memReady) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R6 unexpected beat: actual addr %h be %h expected none", memAddr, memBe);
        end else begin
          beat_t e;
          bit bad;
          e = expQ.pop_front();
          bad = (memAddr !== e.addr) || (memBe !== e.be);
          for (int j = 0; j < 16; j++)
            if (e.be[j] && memData[8*j +: 8] !== e.data[8*j +: 8]) bad = 1'b1;
          if (bad) begin
            errors++;
            $display("FAIL R1/R2/R3/R4/R7 beat: actual addr %h be %h data %h expected addr %h be %h data %h",
                     memAddr, memBe, memData, e.addr, e.be, e.data);
          end
        end
      end
    end
  end

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (reqReady !== 1'b1 || memValid !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: actual ready %0b valid %0b expected 1 0", reqReady, memValid);
    end
    rstN = 1'b1;

    // R1 R3 R5: aligned, full mask, single beat
    send(128'h0F0E0D0C0B0A09080706050403020100, {16{8'h80}}, 64'h1000, 2'd2);
    // R2 R4 R7: offset 5, two beats
    send(128'hFFEEDDCCBBAA99887766554433221100, {16{8'hFF}}, 64'h2005, 2'd2);
    // R2: offset 15 with only byte 0 -> lower lane 15
    send(r128(), 128'h80, 64'h300F, 2'd2);
    // R6: only byte 15 at offset 1 -> lower beat skipped
    send(r128(), {8'h80, 120'h0}, 64'h4001, 2'd2);
    // R1 R6: low seven bits set everywhere -> no write
    send(r128(), {16{8'h7F}}, 64'h5003, 2'd2);
    repeat (4) begin
      @(negedge clk); #1;
      checks++;
      if (memValid !== 1'b0) begin
        errors++;
        $display("FAIL R6 empty mask: actual valid %0b expected 0", memValid);
      end
    end
    // R1: alternating enables with noise in low bits
    send(r128(), {8{8'h81, 8'h3C}}, 64'h6008, 2'd2);
    // R4: 16-bit wrap
    send(r128(), {16{8'h80}}, 64'hDEAD_BEEF_1234_FFF8, 2'd0);
    // R4: 32-bit wrap
    send(r128(), {16{8'h80}}, 64'hABCD_0001_FFFF_FFF3, 2'd1);
    // R3: 64-bit mode keeps high bits; mode 3 acts as 64-bit
    send(r128(), {16{8'h80}}, 64'hFFFF_FFFF_FFFF_FFF9, 2'd3);
    drain();

    // R9 under heavy stalls, then random mix
    readyPct = 30;
    for (int n = 0; n < 30; n++)
      send(r128(), r128(), {$urandom, $urandom}, 2'($urandom_range(3)));
    readyPct = 90;
    for (int n = 0; n < 30; n++)
      send(r128(), r128() & r128(), {$urandom, $urandom}, 2'($urandom_range(3)));
    drain();

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R6/R7 leftover beats: actual %0d expected 0", expQ.size());
    end
    done = 1'b1;
    finishRun();
  end
endmodule